// File: doc/BRIEF.md
# Indexed Colour Lookup Table with Byte Register Port

This block holds a 256-entry colour table, each entry made of a red, a green and a blue byte. A host reaches it through a narrow byte-wide register interface with three ports. It writes a starting entry number to a write-pointer port, then pushes colour bytes one at a time into a shared data port. Every third byte completes an entry, and the pointer then steps to the next entry without further help. A whole palette, or any run of consecutive entries, therefore loads with one pointer write followed by a continuous byte stream.

Read-back works the same way. A separate read-pointer port selects the first entry to read, and successive reads of the data port return red, green and blue of that entry before moving on to the next. On the display side, a pixel lookup port turns an 8-bit pixel value into its 24-bit colour one clock later. The pixel side only ever sees whole entries, because an entry is written into the table in a single step when its blue byte arrives.

Top module: `palette_ram`

## Requirements
- R1: While reset is asserted and after its release until the first access, `pix_color` and `reg_rdata` are 0, and the write pointer and read pointer both read back as 0 with the component phase at red.
- R2: A write to offset 0x08 loads the write pointer with the written byte and restarts the write component phase at red.
- R3: Successive writes to offset 0x09 supply red, then green, then blue of the entry under the write pointer; an entry reads on `pix_color` packed as red in bits 23:16, green in 15:8, blue in 7:0.
- R4: The blue write moves the write pointer to the next entry, wrapping from 255 to 0, so N entries load with 3N data writes.
- R5: An entry changes in the table only on its blue write; after a red or green write alone the pixel port still returns the old colour.
- R6: A write to offset 0x07 loads the read pointer and restarts the read phase at red; reads of offset 0x09 return red, green, blue of the entry under the read pointer, then advance it with wrap from 255 to 0.
- R7: `pix_color` shows the entry selected by `pix_idx` one clock after `pix_idx` is sampled, and holds its previous value until that edge.
- R8: `reg_rdata` updates on the clock after a read strobe and holds otherwise; reads of 0x08 and 0x07 return the write and read pointers, reads of any other offset except 0x09 return 0, and writes to any other offset change nothing.
- R9: Rewriting the write pointer in the middle of an entry drops the bytes staged so far; they never reach the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte, valid the clock after `reg_rd` |
| pix_idx | input | 8 | Pixel value to look up |
| pix_color | output | 24 | Colour of the looked-up entry, one clock after `pix_idx` |

## Verification
The hardest situation to reach is a partial entry: a red or green byte held in staging while the pixel port, a pointer rewrite or a read-back touches the same entry. The bench loads the whole table first so every entry has a known colour, then probes the pixel port between each byte of a directed triplet, abandons a triplet midway by rewriting the pointer, and runs a long random mix of pointer writes, data writes, data reads and pixel lookups in which the component phase is often neither red nor blue when the next operation arrives. Directed runs starting at entry 255 drive both pointers across the wrap.

// File: rtl/pal_pkg.sv
package pal_pkg;

  // Which register port a host access selects.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RPTR = 2'd1,
    SEL_WPTR = 2'd2,
    SEL_DATA = 2'd3
  } port_sel_e;

endpackage

// File: rtl/pal_port_decode.sv
module pal_port_decode
  import pal_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RPTR_OFS = 7,
  parameter int WPTR_OFS = 8,
  parameter int DATA_OFS = 9
) (
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr,
  output port_sel_e         sel
);

  localparam logic [ADDR_W-1:0] RPTR_A = ADDR_W'(RPTR_OFS);
  localparam logic [ADDR_W-1:0] WPTR_A = ADDR_W'(WPTR_OFS);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);

  always_comb begin
    sel = SEL_NONE;
    if (strobe) begin
      if (addr == RPTR_A)      sel = SEL_RPTR;
      else if (addr == WPTR_A) sel = SEL_WPTR;
      else if (addr == DATA_A) sel = SEL_DATA;
    end
  end

endmodule

// File: rtl/pal_triplet_seq.sv
module pal_triplet_seq #(
  parameter int ENTRIES = 256,
  parameter int NCOMP   = 3,
  parameter int LOAD_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PH_W   = $clog2(NCOMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LOAD_W-1:0] load_val,
  input  logic              step,
  output logic [IDX_W-1:0]  ptr,
  output logic [PH_W-1:0]   phase,
  output logic              last
);

  localparam logic [IDX_W-1:0] PTR_TOP = IDX_W'(ENTRIES - 1);
  localparam logic [PH_W-1:0]  PH_TOP  = PH_W'(NCOMP - 1);

  logic [IDX_W-1:0] ptr_d;
  logic [PH_W-1:0]  phase_d;
  logic             upd;

  assign last = (phase == PH_TOP);
  assign upd  = load | step;

  always_comb begin
    ptr_d   = ptr;
    phase_d = phase;
    if (load) begin
      ptr_d   = load_val[IDX_W-1:0];
      phase_d = '0;
    end else if (step) begin
      if (last) begin
        phase_d = '0;
        ptr_d   = (ptr == PTR_TOP) ? '0 : ptr + 1'b1;
      end else begin
        phase_d = phase + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      phase <= '0;
    end else if (upd) begin
      ptr   <= ptr_d;
      phase <= phase_d;
    end
  end

endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int ENTRIES = 256,
  parameter int ENTRY_W = 24,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   waddr,
  input  logic [ENTRY_W-1:0] wentry,
  input  logic [IDX_W-1:0]   host_addr,
  output logic [ENTRY_W-1:0] host_entry,
  input  logic [IDX_W-1:0]   pix_addr,
  output logic [ENTRY_W-1:0] pix_entry
);

  logic [ENTRY_W-1:0] mem [ENTRIES];

  // Table storage: datapath only, no reset.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wentry;
  end

  assign host_entry = mem[host_addr];

  // Registered pixel lookup.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_entry <= '0;
    else        pix_entry <= mem[pix_addr];
  end

endmodule

// File: rtl/palette_ram.sv
module palette_ram
  import pal_pkg::*;
#(
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 8,
  parameter int NCOMP    = 3,
  parameter int ADDR_W   = 4,
  parameter int RPTR_OFS = 7,
  parameter int WPTR_OFS = 8,
  parameter int DATA_OFS = 9,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int PH_W    = $clog2(NCOMP),
  localparam int ENTRY_W = NCOMP * COMP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [COMP_W-1:0]  reg_wdata,
  output logic [COMP_W-1:0]  reg_rdata,
  input  logic [IDX_W-1:0]   pix_idx,
  output logic [ENTRY_W-1:0] pix_color
);

  port_sel_e wsel;
  port_sel_e rsel;

  logic [IDX_W-1:0] wr_ptr;
  logic [PH_W-1:0]  wr_phase;
  logic             wr_last;
  logic [IDX_W-1:0] rd_ptr;
  logic [PH_W-1:0]  rd_phase;
  logic             rd_last;

  logic               data_wr;
  logic               data_rd;
  logic               commit_we;
  logic [ENTRY_W-1:0] commit_entry;
  logic [ENTRY_W-1:0] host_entry;
  logic [COMP_W-1:0]  host_comp;
  logic [COMP_W-1:0]  rdata_d;

  // Host port decode, one per strobe.
  pal_port_decode #(
    .ADDR_W(ADDR_W), .RPTR_OFS(RPTR_OFS), .WPTR_OFS(WPTR_OFS), .DATA_OFS(DATA_OFS)
  ) u_wdec (
    .strobe(reg_wr), .addr(reg_addr), .sel(wsel)
  );

  pal_port_decode #(
    .ADDR_W(ADDR_W), .RPTR_OFS(RPTR_OFS), .WPTR_OFS(WPTR_OFS), .DATA_OFS(DATA_OFS)
  ) u_rdec (
    .strobe(reg_rd), .addr(reg_addr), .sel(rsel)
  );

  assign data_wr   = (wsel == SEL_DATA);
  assign data_rd   = (rsel == SEL_DATA);
  assign commit_we = data_wr & wr_last;

  // Write side pointer and component phase.
  pal_triplet_seq #(
    .ENTRIES(ENTRIES), .NCOMP(NCOMP), .LOAD_W(COMP_W)
  ) u_wseq (
    .clk(clk), .rst_n(rst_n),
    .load(wsel == SEL_WPTR), .load_val(reg_wdata), .step(data_wr),
    .ptr(wr_ptr), .phase(wr_phase), .last(wr_last)
  );

  // Read-back side pointer and component phase.
  pal_triplet_seq #(
    .ENTRIES(ENTRIES), .NCOMP(NCOMP), .LOAD_W(COMP_W)
  ) u_rseq (
    .clk(clk), .rst_n(rst_n),
    .load(wsel == SEL_RPTR), .load_val(reg_wdata), .step(data_rd),
    .ptr(rd_ptr), .phase(rd_phase), .last(rd_last)
  );

  // Staging for all components but the last; component k sits at the
  // top of the entry for k = 0 (red first, most significant).
  genvar k;
  generate
    for (k = 0; k < NCOMP - 1; k++) begin : g_stage
      logic [COMP_W-1:0] stage_q;
      logic              stage_en;
      assign stage_en = data_wr & (wr_phase == PH_W'(k));
      always_ff @(posedge clk) begin
        if (stage_en) stage_q <= reg_wdata;
      end
      assign commit_entry[(NCOMP-1-k)*COMP_W +: COMP_W] = stage_q;
    end
  endgenerate

  assign commit_entry[COMP_W-1:0] = reg_wdata;

  pal_store #(
    .ENTRIES(ENTRIES), .ENTRY_W(ENTRY_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(commit_we), .waddr(wr_ptr), .wentry(commit_entry),
    .host_addr(rd_ptr), .host_entry(host_entry),
    .pix_addr(pix_idx), .pix_entry(pix_color)
  );

  // Component of the read-back entry selected by the read phase.
  always_comb begin
    host_comp = '0;
    for (int c = 0; c < NCOMP; c++) begin
      if (rd_phase == PH_W'(c)) host_comp = host_entry[(NCOMP-1-c)*COMP_W +: COMP_W];
    end
  end

  always_comb begin
    unique case (rsel)
      SEL_RPTR: rdata_d = COMP_W'(rd_ptr);
      SEL_WPTR: rdata_d = COMP_W'(wr_ptr);
      SEL_DATA: rdata_d = host_comp;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rdata_d;
  end

endmodule

// File: rtl/palette_ram_chk.sv
module palette_ram_chk #(
  parameter int ENTRIES  = 256,
  parameter int COMP_W   = 8,
  parameter int NCOMP    = 3,
  parameter int ADDR_W   = 4,
  parameter int RPTR_OFS = 7,
  parameter int WPTR_OFS = 8,
  parameter int DATA_OFS = 9,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int PH_W    = $clog2(NCOMP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [COMP_W-1:0] reg_wdata,
  input logic [IDX_W-1:0]  wr_ptr,
  input logic [PH_W-1:0]   wr_phase,
  input logic [IDX_W-1:0]  rd_ptr,
  input logic [PH_W-1:0]   rd_phase,
  input logic              commit_we
);

  localparam logic [ADDR_W-1:0] RP = ADDR_W'(RPTR_OFS);
  localparam logic [ADDR_W-1:0] WP = ADDR_W'(WPTR_OFS);
  localparam logic [ADDR_W-1:0] DP = ADDR_W'(DATA_OFS);
  localparam logic [PH_W-1:0]   PL = PH_W'(NCOMP - 1);
  localparam logic [IDX_W-1:0]  PT = IDX_W'(ENTRIES - 1);

  a_r2_wptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == WP) |=> (wr_ptr == $past(reg_wdata[IDX_W-1:0]) && wr_phase == '0));

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == DP && wr_phase != PL) |=>
      (wr_phase == PH_W'($past(wr_phase) + 1'b1) && $stable(wr_ptr)));

  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_phase <= PL && rd_phase <= PL));

  a_r4_wptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == DP && wr_phase == PL) |=>
      (wr_phase == '0 && wr_ptr == (($past(wr_ptr) == PT) ? '0 : IDX_W'($past(wr_ptr) + 1'b1))));

  a_r5_commit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> (reg_wr && reg_addr == DP && wr_phase == PL));

  a_r6_rptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == DP && rd_phase == PL && !(reg_wr && reg_addr == RP)) |=>
      (rd_phase == '0 && rd_ptr == (($past(rd_ptr) == PT) ? '0 : IDX_W'($past(rd_ptr) + 1'b1))));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr) |=> ($stable(wr_ptr) && $stable(wr_phase)));

endmodule

bind palette_ram palette_ram_chk #(
  .ENTRIES(ENTRIES), .COMP_W(COMP_W), .NCOMP(NCOMP), .ADDR_W(ADDR_W),
  .RPTR_OFS(RPTR_OFS), .WPTR_OFS(WPTR_OFS), .DATA_OFS(DATA_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .wr_ptr(wr_ptr), .wr_phase(wr_phase), .rd_ptr(rd_ptr), .rd_phase(rd_phase),
  .commit_we(commit_we)
);

// File: tb/palette_ram_bench.sv
`timescale 1ns/1ps
module palette_ram_bench;

  localparam logic [3:0] A_RP = 4'h7;
  localparam logic [3:0] A_WP = 4'h8;
  localparam logic [3:0] A_DT = 4'h9;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  pix_idx;
  logic [23:0] pix_color;

  always #2 clk = ~clk;

  palette_ram u_palette_ram (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_idx(pix_idx), .pix_color(pix_color)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] model [256];
  logic [7:0]  mwptr, mrptr, sr, sg;
  int          mwph, mrph;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] comp_of(input logic [23:0] e, input int ph);
    return (ph == 0) ? e[23:16] : (ph == 1) ? e[15:8] : e[7:0];
  endfunction

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == A_WP) begin mwptr = d; mwph = 0; end
    else if (a == A_RP) begin mrptr = d; mrph = 0; end
    else if (a == A_DT) begin
      if (mwph == 0) begin sr = d; mwph = 1; end
      else if (mwph == 1) begin sg = d; mwph = 2; end
      else begin model[mwptr] = {sr, sg, d}; mwptr = mwptr + 8'd1; mwph = 0; end
    end
  endtask

  task automatic rd_chk(input logic [3:0] a, input string req);
    logic [7:0] exp;
    if (a == A_WP) exp = mwptr;
    else if (a == A_RP) exp = mrptr;
    else if (a == A_DT) begin
      exp = comp_of(model[mrptr], mrph);
      if (mrph == 2) begin mrph = 0; mrptr = mrptr + 8'd1; end
      else mrph++;
    end else exp = 8'h00;
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    chk(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic pix_chk(input logic [7:0] i, input string req);
    pix_idx = i;
    @(negedge clk);
    chk(req, 32'(pix_color), 32'(model[i]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; pix_idx = '0;
    mwptr = 0; mrptr = 0; mwph = 0; mrph = 0; sr = 0; sg = 0;
    repeat (3) @(negedge clk);
    chk("R1 pix_color in reset", 32'(pix_color), 0);
    chk("R1 reg_rdata in reset", 32'(reg_rdata), 0);
    rst_n = 1'b1;
    chk("R1 pix_color at release", 32'(pix_color), 0);
    @(negedge clk);
    chk("R1 reg_rdata held", 32'(reg_rdata), 0);
    rd_chk(A_WP, "R1 write pointer");
    rd_chk(A_RP, "R1 read pointer");

    // Fill whole table with one pointer write.
    wr(A_WP, 8'd0);
    for (int i = 0; i < 768; i++) wr(A_DT, 8'($urandom));
    rd_chk(A_WP, "R4 pointer wrapped after 768 bytes");
    for (int i = 0; i < 40; i++) pix_chk(8'($urandom), "R3 random lookup");

    // Latency: value changes only at the edge after pix_idx is sampled.
    pix_chk(8'd5, "R7 first lookup");
    pix_idx = 8'd6;
    #1 chk("R7 holds before edge", 32'(pix_color), 32'(model[5]));
    @(negedge clk);
    chk("R7 updates after edge", 32'(pix_color), 32'(model[6]));

    // Partial entry must stay invisible.
    wr(A_WP, 8'd10);
    wr(A_DT, 8'hA1);
    pix_chk(8'd10, "R5 after red only");
    wr(A_DT, 8'hB2);
    pix_chk(8'd10, "R5 after green");
    wr(A_DT, 8'hC3);
    chk("R3 model packing", 32'(model[10]), 32'h00A1B2C3);
    pix_chk(8'd10, "R3 entry complete");
    rd_chk(A_WP, "R4 pointer advanced");

    // Abandon a partial entry.
    wr(A_WP, 8'd20);
    wr(A_DT, 8'h11); wr(A_DT, 8'h22);
    wr(A_WP, 8'd20);
    rd_chk(A_WP, "R2 pointer reloaded");
    wr(A_DT, 8'h44);
    pix_chk(8'd20, "R9 abandoned bytes not committed");
    wr(A_DT, 8'h55); wr(A_DT, 8'h66);
    pix_chk(8'd20, "R9 restart at red");
    pix_chk(8'd21, "R9 neighbour untouched");

    // Write wrap.
    wr(A_WP, 8'd255);
    for (int i = 0; i < 6; i++) wr(A_DT, 8'($urandom));
    pix_chk(8'd255, "R4 last entry");
    pix_chk(8'd0, "R4 wrapped entry");
    rd_chk(A_WP, "R4 pointer after wrap");

    // Read-back.
    wr(A_RP, 8'd10);
    for (int i = 0; i < 15; i++) rd_chk(A_DT, "R6 read-back stream");
    wr(A_RP, 8'd254);
    for (int i = 0; i < 9; i++) rd_chk(A_DT, "R6 read-back wrap");
    rd_chk(A_RP, "R6 read pointer after wrap");
    wr(A_RP, 8'd30);
    rd_chk(A_DT, "R6 partial read");
    wr(A_RP, 8'd30);
    rd_chk(A_DT, "R6 read phase restart");

    // Unmapped offsets.
    wr(4'h3, 8'h5A);
    wr(4'hF, 8'hA5);
    rd_chk(A_WP, "R8 unmapped write ignored");
    rd_chk(4'h3, "R8 unmapped read zero");
    rd_chk(4'hF, "R8 unmapped read zero");
    pix_chk(8'd0, "R8 table untouched");
    reg_addr = A_WP;
    repeat (2) @(negedge clk);
    chk("R8 rdata held without strobe", 32'(reg_rdata), 32'h0);

    // Random mix.
    for (int n = 0; n < 400; n++) begin
      int op;
      op = int'($urandom % 8);
      case (op)
        0:       wr(A_WP, 8'($urandom));
        1,2,3,4: wr(A_DT, 8'($urandom));
        5:       wr(A_RP, 8'($urandom));
        6:       rd_chk(A_DT, "R6 random read-back");
        default: pix_chk(8'($urandom), "R3 random lookup in mix");
      endcase
    end
    rd_chk(A_WP, "R2 random pointer track");
    for (int i = 0; i < 256; i++) pix_chk(8'(i), "R5 final table sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule